// File: doc/BRIEF.md
# DMA Channel Element Transfer Engine

This block is the data-moving core of a multi-channel DMA controller. For every channel it keeps a source address, a destination address, a control word and a configuration word. When the controller-wide enable is high, it looks over the channels before each element. It picks the lowest-numbered channel that is allowed to move data and moves one element for it. The element is fetched from the source and stored at the destination through a memory port that has one request outstanding at a time. The engine then steps the addresses and counts down the channel's remaining element count.

Whether a channel may move data depends on its enable and halt bits, its remaining count and a 3-bit flow code. The flow code says which peripheral request lines must be high: none, the destination's, the source's, or both. The lines looked at are the OR of a single-request vector and a burst-request vector. Flow codes 4 to 7 stand for peripheral-controlled flow, which this engine does not run. A channel with such a code raises a one-cycle error pulse and is switched off. Descriptor chaining belongs to a separate loader, which reaches the channel registers through the same write port that software uses.

Top module: `dma_elem_engine`

## Requirements
- R1: After synchronous reset, no memory request or error pulse is issued, and every channel register reads back as zero.
- R2: While `glb_en` is low, no memory request and no error pulse is started.
- R3: A channel is considered only when its configuration bit 0 (enable) is 1 and its configuration bit 18 (halt) is 0.
- R4: Configuration bits [13:11] hold the flow code. Bits [5:1] give the source peripheral line and bits [10:6] the destination line. Code 0 needs no line, 1 needs the destination line, 2 the source line and 3 both. The line vector is `req_single | req_burst`.
- R5: Control bits [11:0] hold the remaining count, and a channel whose count is zero is never served.
- R6: An element is a read at the source address with `mem_size` = control[20:18], followed by a write at the destination address with `mem_size` = control[23:21] that carries the read data. A completion (`mem_rsp_valid`) is taken only in a cycle after the request was accepted. No new request is made before it arrives.
- R7: After each element, the source address grows by 1 << control[20:18] if control bit 26 is set, and the destination address grows by 1 << control[23:21] if control bit 27 is set; otherwise each stays unchanged.
- R8: After each element, control[11:0] drops by one and control[31:12] is preserved.
- R9: Before each element, the lowest-indexed channel that is eligible is chosen.
- R10: An enabled, non-halted channel with flow code 4 to 7 gives a one-cycle `err_pulse` with its index on `err_ch`. Its enable bit is cleared, and no memory request is made for it.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address, size and write flag stay unchanged.
- R12: The register port selects source (0), destination (1), control (2) or configuration (3) with `wr_sel`/`rd_sel`. Read data shows on `rd_data` one cycle after `rd_ch`/`rd_sel` are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Controller-wide enable |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CHW | Channel written |
| wr_sel | input | 2 | Register written (0 src, 1 dst, 2 ctrl, 3 conf) |
| wr_data | input | 32 | Write data |
| rd_ch | input | CHW | Channel read |
| rd_sel | input | 2 | Register read |
| rd_data | output | 32 | Read data, one cycle later |
| req_single | input | 32 | Single-request lines from peripherals |
| req_burst | input | 32 | Burst-request lines from peripherals |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_addr | output | AW | Request byte address |
| mem_size | output | 3 | Log2 of bytes moved |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Completion of the accepted request |
| mem_rsp_rdata | input | DW | Read data on completion |
| err_pulse | output | 1 | Peripheral-flow error, one cycle |
| err_ch | output | CHW | Channel that raised the error |

## Verification
The choice of channel is made on the clock edge after the channel becomes eligible. The first request or error pulse of an element is therefore visible on the first falling edge after that rising edge. The write request follows one edge after the read completion, and the register update follows one edge after the write completion. The bench drives every input on a falling edge and samples every output on a falling edge. It compares each accepted request and error pulse, in order, against the next event its behavioural model predicts, instead of counting fixed cycles. Register reads are sampled one full cycle after the select is driven.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RDW, ST_WR, ST_WRW
  } eng_st_e;

  localparam int REQ_LINES = 32;
  localparam int REG_W     = 32;

  // configuration word fields
  localparam int CF_EN    = 0;
  localparam int CF_SPER  = 1;
  localparam int CF_DPER  = 6;
  localparam int CF_FLOW  = 11;
  localparam int CF_HALT  = 18;
  // control word fields
  localparam int CT_CNT_W = 12;
  localparam int CT_SSZ   = 18;
  localparam int CT_DSZ   = 21;
  localparam int CT_SINC  = 26;
  localparam int CT_DINC  = 27;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_CONF = 2'd3;
endpackage

// File: rtl/dma_chan_qual.sv
module dma_chan_qual
  import dma_eng_pkg::*;
(
  input  logic [REG_W-1:0]     conf,
  input  logic [REG_W-1:0]     ctrl,
  input  logic [REQ_LINES-1:0] lines,
  output logic                 want,
  output logic                 flow_err
);
  logic [2:0] flow;
  logic [4:0] sper, dper;
  logic       live, reqs_ok, has_cnt;

  always_comb begin
    flow    = conf[CF_FLOW +: 3];
    sper    = conf[CF_SPER +: 5];
    dper    = conf[CF_DPER +: 5];
    live    = conf[CF_EN] && !conf[CF_HALT];
    has_cnt = ctrl[CT_CNT_W-1:0] != '0;
    unique case (flow)
      3'd0:    reqs_ok = 1'b1;
      3'd1:    reqs_ok = lines[dper];
      3'd2:    reqs_ok = lines[sper];
      3'd3:    reqs_ok = lines[sper] && lines[dper];
      default: reqs_ok = 1'b0;
    endcase
    flow_err = live && flow[2];
    want     = flow_err || (live && has_cnt && reqs_ok);
  end
endmodule

// File: rtl/dma_pick.sv
module dma_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] want,
  output logic         found,
  output logic [W-1:0] idx,
  output logic [N-1:0] grant
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (want[i]) begin
        found = 1'b1;
        idx   = W'(i);
        grant = N'(1) << i;
      end
    end
    AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R9
  end
endmodule

// File: rtl/dma_elem_engine.sv
module dma_elem_engine
  import dma_eng_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 glb_en,
  input  logic                 wr_en,
  input  logic [CHW-1:0]       wr_ch,
  input  logic [1:0]           wr_sel,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [CHW-1:0]       rd_ch,
  input  logic [1:0]           rd_sel,
  output logic [REG_W-1:0]     rd_data,
  input  logic [REQ_LINES-1:0] req_single,
  input  logic [REQ_LINES-1:0] req_burst,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [AW-1:0]        mem_addr,
  output logic [2:0]           mem_size,
  output logic                 mem_write,
  output logic [DW-1:0]        mem_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [DW-1:0]        mem_rsp_rdata,
  output logic                 err_pulse,
  output logic [CHW-1:0]       err_ch
);
  logic [AW-1:0]    src_q  [NCH];
  logic [AW-1:0]    dst_q  [NCH];
  logic [REG_W-1:0] ctrl_q [NCH];
  logic [REG_W-1:0] conf_q [NCH];

  eng_st_e          st_q;
  logic [CHW-1:0]   cur_q;
  logic [NCH-1:0]   want, ferr, grant;
  logic             found;
  logic [CHW-1:0]   pick;
  logic [REQ_LINES-1:0] lines;

  assign lines = req_single | req_burst;

  for (genvar g = 0; g < NCH; g++) begin : g_qual
    dma_chan_qual u_qual (
      .conf     (conf_q[g]),
      .ctrl     (ctrl_q[g]),
      .lines    (lines),
      .want     (want[g]),
      .flow_err (ferr[g])
    );
  end

  dma_pick #(.N(NCH)) u_pick (
    .want  (want),
    .found (found),
    .idx   (pick),
    .grant (grant)
  );

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    unique case (rd_sel)
      SEL_SRC:  rd_mux = REG_W'(src_q[rd_ch]);
      SEL_DST:  rd_mux = REG_W'(dst_q[rd_ch]);
      SEL_CTRL: rd_mux = ctrl_q[rd_ch];
      default:  rd_mux = conf_q[rd_ch];
    endcase
  end

  logic [2:0]  cur_ssz, cur_dsz;
  logic [AW-1:0] src_step, dst_step;
  always_comb begin
    cur_ssz  = ctrl_q[cur_q][CT_SSZ +: 3];
    cur_dsz  = ctrl_q[cur_q][CT_DSZ +: 3];
    src_step = ctrl_q[cur_q][CT_SINC] ? (AW'(1) << cur_ssz) : '0;
    dst_step = ctrl_q[cur_q][CT_DINC] ? (AW'(1) << cur_dsz) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      cur_q         <= '0;
      mem_req_valid <= 1'b0;
      mem_addr      <= '0;
      mem_size      <= '0;
      mem_write     <= 1'b0;
      mem_wdata     <= '0;
      err_pulse     <= 1'b0;
      err_ch        <= '0;
      rd_data       <= '0;
      for (int i = 0; i < NCH; i++) begin
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        ctrl_q[i] <= '0;
        conf_q[i] <= '0;
      end
    end else begin
      err_pulse <= 1'b0;
      rd_data   <= rd_mux;
      unique case (st_q)
        ST_IDLE: begin
          if (glb_en && found) begin
            cur_q <= pick;
            if (ferr[pick]) begin
              err_pulse            <= 1'b1;
              err_ch               <= pick;
              conf_q[pick][CF_EN]  <= 1'b0;
            end else begin
              mem_req_valid <= 1'b1;
              mem_addr      <= src_q[pick];
              mem_size      <= ctrl_q[pick][CT_SSZ +: 3];
              mem_write     <= 1'b0;
              st_q          <= ST_RD;
            end
          end
        end
        ST_RD: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          st_q          <= ST_RDW;
        end
        ST_RDW: if (mem_rsp_valid) begin
          mem_req_valid <= 1'b1;
          mem_addr      <= dst_q[cur_q];
          mem_size      <= cur_dsz;
          mem_write     <= 1'b1;
          mem_wdata     <= mem_rsp_rdata;
          st_q          <= ST_WR;
        end
        ST_WR: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          st_q          <= ST_WRW;
        end
        ST_WRW: if (mem_rsp_valid) begin
          src_q[cur_q]                 <= src_q[cur_q] + src_step;
          dst_q[cur_q]                 <= dst_q[cur_q] + dst_step;
          ctrl_q[cur_q][CT_CNT_W-1:0]  <= ctrl_q[cur_q][CT_CNT_W-1:0] - 1'b1;
          st_q                         <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (wr_en) begin
        unique case (wr_sel)
          SEL_SRC:  src_q[wr_ch]  <= wr_data[AW-1:0];
          SEL_DST:  dst_q[wr_ch]  <= wr_data[AW-1:0];
          SEL_CTRL: ctrl_q[wr_ch] <= wr_data;
          default:  conf_q[wr_ch] <= wr_data;
        endcase
      end
    end
  end

  logic [CT_CNT_W-1:0] cnt_cur;
  logic [REG_W-1:0]    conf_cur;
  assign cnt_cur  = ctrl_q[cur_q][CT_CNT_W-1:0];
  assign conf_cur = conf_q[cur_q];

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_size) && $stable(mem_write))); // R11

  AST_GLB_OFF: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !glb_en) |=> (!mem_req_valid && !err_pulse)); // R2

  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> !mem_req_valid); // R10

  AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req_valid) && !mem_write) |-> (cnt_cur != '0)); // R5

  AST_SERVE_EN: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req_valid) && !mem_write) |-> (conf_cur[CF_EN] && !conf_cur[CF_HALT])); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WRW && mem_rsp_valid && !wr_en) |=> (cnt_cur == $past(cnt_cur) - 1'b1)); // R8
endmodule

// File: tb/dma_elem_engine_tb.sv
module dma_elem_engine_tb;
  localparam int NCH = 4;
  localparam int CHW = 2;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic glb_en = 1'b0;
  logic wr_en = 1'b0;
  logic [CHW-1:0] wr_ch = '0, rd_ch = '0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [31:0] req_single = '0, req_burst = '0;
  logic mem_req_valid, mem_write, err_pulse;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rsp_rdata = '0;
  logic [2:0] mem_size;
  logic [CHW-1:0] err_ch;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  dma_elem_engine #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .glb_en(glb_en),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
    .req_single(req_single), .req_burst(req_burst),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_write(mem_write),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .err_pulse(err_pulse), .err_ch(err_ch)
  );

  // memory responder: stalls on some cycles, answers one cycle after acceptance
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_rdata <= mem_addr ^ KEY;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  // behavioural model state
  logic [31:0] m_src [NCH];
  logic [31:0] m_dst [NCH];
  logic [31:0] m_ctrl[NCH];
  logic [31:0] m_conf[NCH];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wreg(input int ch, input int sel, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = CHW'(ch); wr_sel = 2'(sel); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      0: m_src[ch] = v;
      1: m_dst[ch] = v;
      2: m_ctrl[ch] = v;
      default: m_conf[ch] = v;
    endcase
  endtask

  task automatic rreg(input int ch, input int sel, output logic [31:0] v);
    @(negedge clk);
    rd_ch = CHW'(ch); rd_sel = 2'(sel);
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic logic [31:0] mk_conf(bit en, bit halt, int flow, int sp, int dp);
    return 32'(en) | (32'(sp) << 1) | (32'(dp) << 6) | (32'(flow) << 11) | (32'(halt) << 18);
  endfunction

  function automatic logic [31:0] mk_ctrl(int cnt, int sc, int dc, bit si, bit di);
    return 32'h8000_3000 | 32'(cnt) | (32'(sc) << 18) | (32'(dc) << 21)
           | (32'(si) << 26) | (32'(di) << 27);
  endfunction

  // returns channel chosen (-1 if none), iserr set for peripheral flow codes
  function automatic int m_pick(output bit iserr);
    logic [31:0] r;
    iserr = 1'b0;
    r = req_single | req_burst;
    if (!glb_en) return -1;
    for (int c = 0; c < NCH; c++) begin
      int fl, sp, dp;
      bit ok;
      fl = int'(m_conf[c][13:11]);
      sp = int'(m_conf[c][5:1]);
      dp = int'(m_conf[c][10:6]);
      if (m_conf[c][0] && !m_conf[c][18]) begin
        if (fl >= 4) begin iserr = 1'b1; return c; end
        ok = (fl == 0) || (fl == 1 && r[dp]) || (fl == 2 && r[sp]) ||
             (fl == 3 && r[sp] && r[dp]);
        if (ok && m_ctrl[c][11:0] != 0) return c;
      end
    end
    return -1;
  endfunction

  bit stall_seen = 1'b0;
  logic [31:0] stall_addr;

  task automatic get_event(input int tmo, output int kind, output logic [31:0] a,
                           output logic [2:0] sz, output logic w, output logic [31:0] d,
                           output int ech);
    kind = 0; a = '0; sz = '0; w = 1'b0; d = '0; ech = -1;
    for (int t = 0; t < tmo && kind == 0; t++) begin
      @(negedge clk);
      if (stall_seen)
        chk(mem_req_valid && mem_addr == stall_addr, "R11", "held request addr",
            mem_addr, stall_addr);
      stall_seen = mem_req_valid && !mem_req_ready;
      stall_addr = mem_addr;
      if (mem_req_valid && mem_req_ready) begin
        kind = 1; a = mem_addr; sz = mem_size; w = mem_write; d = mem_wdata;
      end else if (err_pulse) begin
        kind = 2; ech = int'(err_ch);
      end
    end
  endtask

  task automatic expect_quiet(input string req);
    int k, e; logic [31:0] a, d; logic [2:0] s; logic w;
    get_event(40, k, a, s, w, d, e);
    chk(k == 0, req, "no activity expected", k, 0);
  endtask

  task automatic run_model(input string req);
    int k, e, c; logic [31:0] a, d; logic [2:0] s; logic w; bit ie;
    for (int guard = 0; guard < 64; guard++) begin
      c = m_pick(ie);
      if (c < 0) break;
      get_event(300, k, a, s, w, d, e);
      if (ie) begin
        chk(k == 2 && e == c, "R10", "error pulse channel", e, c);
        m_conf[c][0] = 1'b0;
      end else begin
        chk(k == 1 && !w && a == m_src[c] && s == m_ctrl[c][20:18], req,
            "read request addr", a, m_src[c]);
        chk(s == m_ctrl[c][20:18], "R6", "read size", s, m_ctrl[c][20:18]);
        get_event(300, k, a, s, w, d, e);
        chk(k == 1 && w && a == m_dst[c], req, "write request addr", a, m_dst[c]);
        chk(s == m_ctrl[c][23:21] && d == (m_src[c] ^ KEY), "R6", "write data",
            d, m_src[c] ^ KEY);
        if (m_ctrl[c][26]) m_src[c] = m_src[c] + (32'd1 << m_ctrl[c][20:18]);
        if (m_ctrl[c][27]) m_dst[c] = m_dst[c] + (32'd1 << m_ctrl[c][23:21]);
        m_ctrl[c][11:0] = m_ctrl[c][11:0] - 12'd1;
      end
    end
    expect_quiet(req);
  endtask

  task automatic set_glb(input bit v);
    @(negedge clk);
    glb_en = v;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) begin
      m_src[c] = '0; m_dst[c] = '0; m_ctrl[c] = '0; m_conf[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk(!mem_req_valid && !err_pulse, "R1", "outputs idle after reset", mem_req_valid, 0);
    rreg(0, 3, v); chk(v == 0, "R1", "conf after reset", v, 0);
    rreg(2, 0, v); chk(v == 0, "R1", "src after reset", v, 0);

    // R2 global enable gate, then m2m run with increments (R7, R8, R12)
    wreg(0, 0, 32'h0000_1000);
    wreg(0, 1, 32'h0000_2000);
    wreg(0, 2, mk_ctrl(3, 2, 1, 1, 1));
    wreg(0, 3, mk_conf(1, 0, 0, 0, 0));
    expect_quiet("R2");
    rreg(0, 2, v); chk(v == mk_ctrl(3, 2, 1, 1, 1), "R12", "ctrl readback", v, mk_ctrl(3, 2, 1, 1, 1));
    set_glb(1);
    run_model("R6");
    rreg(0, 2, v); chk(v == m_ctrl[0], "R8", "count zero, upper kept", v, m_ctrl[0]);
    rreg(0, 0, v); chk(v == 32'h0000_100C, "R7", "src after 3 x 4 bytes", v, 32'h0000_100C);
    rreg(0, 1, v); chk(v == 32'h0000_2006, "R7", "dst after 3 x 2 bytes", v, 32'h0000_2006);

    // R3 halted channel is left alone, runs after halt is cleared
    set_glb(0);
    wreg(1, 0, 32'h0000_3000);
    wreg(1, 1, 32'h0000_4000);
    wreg(1, 2, mk_ctrl(2, 0, 0, 1, 0));
    wreg(1, 3, mk_conf(1, 1, 0, 0, 0));
    set_glb(1);
    expect_quiet("R3");
    wreg(1, 3, mk_conf(1, 0, 0, 0, 0));
    run_model("R3");
    rreg(1, 1, v); chk(v == 32'h0000_4000, "R7", "dst not incremented", v, 32'h0000_4000);

    // R4 flow codes and request lines
    set_glb(0);
    wreg(2, 0, 32'h0000_5000);
    wreg(2, 1, 32'h0000_6000);
    wreg(2, 2, mk_ctrl(1, 2, 2, 1, 1));
    wreg(2, 3, mk_conf(1, 0, 1, 0, 7));
    set_glb(1);
    expect_quiet("R4");
    @(negedge clk); req_single[7] = 1'b1;
    run_model("R4");

    set_glb(0);
    wreg(3, 0, 32'h0000_7000);
    wreg(3, 1, 32'h0000_7800);
    wreg(3, 2, mk_ctrl(2, 0, 0, 1, 1));
    wreg(3, 3, mk_conf(1, 0, 2, 20, 0));
    set_glb(1);
    expect_quiet("R4");
    @(negedge clk); req_burst[20] = 1'b1;
    run_model("R4");

    set_glb(0);
    wreg(0, 0, 32'h0000_8000);
    wreg(0, 1, 32'h0000_9000);
    wreg(0, 2, mk_ctrl(1, 2, 2, 1, 1));
    wreg(0, 3, mk_conf(1, 0, 3, 3, 30));
    @(negedge clk); req_single[3] = 1'b1;
    set_glb(1);
    expect_quiet("R4");
    @(negedge clk); req_burst[30] = 1'b1;
    run_model("R4");

    // R9 ascending priority between two ready channels
    set_glb(0);
    wreg(3, 0, 32'h0000_A000);
    wreg(3, 1, 32'h0000_A800);
    wreg(3, 2, mk_ctrl(2, 2, 2, 1, 1));
    wreg(3, 3, mk_conf(1, 0, 0, 0, 0));
    wreg(1, 0, 32'h0000_B000);
    wreg(1, 1, 32'h0000_B800);
    wreg(1, 2, mk_ctrl(2, 2, 2, 1, 1));
    wreg(1, 3, mk_conf(1, 0, 0, 0, 0));
    set_glb(1);
    run_model("R9");

    // R5 zero count skipped
    set_glb(0);
    wreg(2, 2, mk_ctrl(0, 0, 0, 1, 1));
    wreg(2, 3, mk_conf(1, 0, 0, 0, 0));
    set_glb(1);
    expect_quiet("R5");

    // R10 peripheral-controlled flow code gives error and disables
    set_glb(0);
    wreg(3, 2, mk_ctrl(1, 0, 0, 1, 1));
    wreg(3, 3, mk_conf(1, 0, 5, 0, 0));
    set_glb(1);
    run_model("R10");
    rreg(3, 3, v); chk(v[0] == 1'b0, "R10", "enable cleared", v[0], 0);

    // R7 no-increment repeated element
    set_glb(0);
    wreg(0, 0, 32'h0000_C000);
    wreg(0, 1, 32'h0000_D000);
    wreg(0, 2, mk_ctrl(3, 0, 0, 0, 0));
    wreg(0, 3, mk_conf(1, 0, 0, 0, 0));
    set_glb(1);
    run_model("R7");
    rreg(0, 0, v); chk(v == 32'h0000_C000, "R7", "src held", v, 32'h0000_C000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule